// File: doc/BRIEF.md
# Packed Floating-Point Category Tester

The block inspects every floating-point element of a 512-bit data word and reports, one bit per element, whether that element falls into any of the special categories chosen by an 8-bit select code. Elements are 32-bit single precision or 64-bit double precision. The active vector may be 128, 256 or 512 bits wide, which sets how many elements are examined. A scalar option examines only element 0. An optional write mask forces the result bit of each disabled element to zero.

Operations arrive on a valid/ready input channel and leave on a valid/ready output channel through a single result register. The input is accepted on a rising edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the result register is empty or is being drained in the same cycle. A result stays on `out_mask` with `out_valid` high, unchanged, until the cycle in which `out_ready` is high. The operand fields are sampled only in the cycle of acceptance.

Top module: `fpc_class_unit`

## Requirements
- R1: Select code bits map to categories as follows: bit 0 quiet NaN, bit 1 positive zero, bit 2 negative zero, bit 3 positive infinity, bit 4 negative infinity, bit 5 denormal, bit 6 negative, bit 7 signaling NaN. An element's result bit is 1 when it belongs to at least one category whose bit is set. With code 0x18, only infinities of either sign give 1.
- R2: An element is a NaN when its exponent field is all ones and its fraction is non-zero. It is quiet when the top fraction bit is 1 and signaling when that bit is 0.
- R3: An element is denormal when its exponent is zero and its fraction is non-zero, whatever its sign. The negative category holds any element with sign 1 that is neither a zero, an infinity nor a NaN, and this includes negative denormals.
- R4: Element i occupies `in_data[i*32 +: 32]` in single precision (`in_double`=0) and `in_data[i*64 +: 64]` in double precision (`in_double`=1). Its result is `out_mask[i]`.
- R5: `in_width` code 0 selects 128 bits, code 1 selects 256 bits, and codes 2 and 3 select 512 bits. That gives 4, 8 or 16 elements in single precision and 2, 4 or 8 in double precision. Result bits at and above the element count are 0.
- R6: When `in_scalar`=1, only element 0 is tested and all other result bits are 0.
- R7: When `in_mask_en`=1, result bit i is 0 whenever `in_mask[i]` is 0. When `in_mask_en`=0, `in_mask` has no effect.
- R8: A select code of 0 gives an all-zero result for any data.
- R9: An accepted operation's result appears with `out_valid`=1 on the edge after acceptance. It is held stable until it is taken with `out_ready`=1. `in_ready` = !out_valid || out_ready, and results leave in acceptance order.
- R10: A synchronous reset clears `out_valid` and `out_mask` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_double | input | 1 | 1 = 64-bit elements, 0 = 32-bit elements |
| in_width | input | 2 | Vector width code (0:128, 1:256, 2/3:512) |
| in_scalar | input | 1 | Test element 0 only |
| in_mask_en | input | 1 | Apply the write mask |
| in_imm | input | 8 | Category select code |
| in_data | input | 512 | Packed elements, element 0 in the low bits |
| in_mask | input | 16 | Write mask, bit i for element i |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_mask | output | 16 | One result bit per element |

## Verification
The bench targets the following cases:
- It contrasts quiet and signaling NaNs, so a design that decodes the wrong fraction bit swaps the two results.
- It puts negative denormals, negative zero and negative infinity under the negative and denormal codes, which exposes a sign test that takes in the excluded classes.
- It fills every element with an infinity at each width and precision, and under scalar mode, so a wrong element count or a leaking upper bit shows up as extra ones.
- It applies a sparse write mask, and it runs a stretch with a stalling consumer, where any lost, repeated or reordered result breaks the scoreboard order.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int CAT_W = 8;

  localparam int CAT_QNAN = 0;
  localparam int CAT_PZERO = 1;
  localparam int CAT_NZERO = 2;
  localparam int CAT_PINF = 3;
  localparam int CAT_NINF = 4;
  localparam int CAT_DENORM = 5;
  localparam int CAT_NEG = 6;
  localparam int CAT_SNAN = 7;

  localparam int SP_EXP = 8;
  localparam int SP_FRAC = 23;
  localparam int DP_EXP = 11;
  localparam int DP_FRAC = 52;

  typedef enum logic [1:0] {
    VW_128 = 2'd0,
    VW_256 = 2'd1,
    VW_512 = 2'd2,
    VW_MAX = 2'd3
  } vec_width_e;

  function automatic int active_lanes(input logic [1:0] wcode, input int elem_bits,
                                      input int vec_bits);
    int bits;
    case (vec_width_e'(wcode))
      VW_128: bits = 128;
      VW_256: bits = 256;
      default: bits = vec_bits;
    endcase
    if (bits > vec_bits) bits = vec_bits;
    return bits / elem_bits;
  endfunction
endpackage

// File: rtl/fpc_lane_classify.sv
module fpc_lane_classify
  import fpc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int FRAC_W = 23,
  localparam int ELEM_W = 1 + EXP_W + FRAC_W
) (
  input  logic [ELEM_W-1:0] elem,
  input  logic [CAT_W-1:0]  sel,
  output logic [CAT_W-1:0]  cats,
  output logic              hit
);
  logic              sgn;
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic exp_ones, exp_zero, frac_zero, is_nan, is_inf, is_zero;

  assign sgn  = elem[ELEM_W-1];
  assign expo = elem[ELEM_W-2 -: EXP_W];
  assign frac = elem[FRAC_W-1:0];

  assign exp_ones  = &expo;
  assign exp_zero  = ~|expo;
  assign frac_zero = ~|frac;
  assign is_nan    = exp_ones & ~frac_zero;
  assign is_inf    = exp_ones & frac_zero;
  assign is_zero   = exp_zero & frac_zero;

  always_comb begin
    cats = '0;
    cats[CAT_QNAN]   = is_nan & frac[FRAC_W-1];
    cats[CAT_SNAN]   = is_nan & ~frac[FRAC_W-1];
    cats[CAT_PZERO]  = is_zero & ~sgn;
    cats[CAT_NZERO]  = is_zero & sgn;
    cats[CAT_PINF]   = is_inf & ~sgn;
    cats[CAT_NINF]   = is_inf & sgn;
    cats[CAT_DENORM] = exp_zero & ~frac_zero;
    cats[CAT_NEG]    = sgn & ~is_zero & ~exp_ones;
  end

  assign hit = |(cats & sel);

  // R2 R3: the exact classes are mutually exclusive, negative never overlaps NaN or infinity
  always_comb begin
    a_r2_classes_exclusive: assert ($onehot0({cats[CAT_QNAN], cats[CAT_SNAN], cats[CAT_PZERO],
                                             cats[CAT_NZERO], cats[CAT_PINF], cats[CAT_NINF],
                                             cats[CAT_DENORM]}));
    a_r3_neg_excludes_special: assert (!(cats[CAT_NEG] && (cats[CAT_QNAN] || cats[CAT_SNAN]
                                        || cats[CAT_NINF] || cats[CAT_NZERO])));
  end
endmodule

// File: rtl/fpc_lane_bank.sv
module fpc_lane_bank
  import fpc_pkg::*;
#(
  parameter int LANES = 16,
  parameter int EXP_W = 8,
  parameter int FRAC_W = 23,
  localparam int ELEM_W = 1 + EXP_W + FRAC_W,
  localparam int BANK_W = LANES * ELEM_W
) (
  input  logic [BANK_W-1:0] data,
  input  logic [CAT_W-1:0]  sel,
  output logic [LANES-1:0]  hits
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CAT_W-1:0] cats_unused;
    fpc_lane_classify #(
      .EXP_W (EXP_W),
      .FRAC_W(FRAC_W)
    ) i_cls (
      .elem(data[g*ELEM_W +: ELEM_W]),
      .sel (sel),
      .cats(cats_unused),
      .hit (hits[g])
    );
  end
endmodule

// File: rtl/fpc_mask_shape.sv
module fpc_mask_shape
  import fpc_pkg::*;
#(
  parameter int VEC_W = 512,
  localparam int OUT_W = VEC_W / 32,
  localparam int DP_N = VEC_W / 64
) (
  input  logic [OUT_W-1:0] sp_hits,
  input  logic [DP_N-1:0]  dp_hits,
  input  logic             is_double,
  input  logic [1:0]       wcode,
  input  logic             scalar,
  input  logic             mask_en,
  input  logic [OUT_W-1:0] wmask,
  output logic [OUT_W-1:0] result
);
  int               n_lanes;
  logic [OUT_W-1:0] raw;
  logic [OUT_W-1:0] lane_on;

  always_comb begin
    if (scalar) n_lanes = 1;
    else if (is_double) n_lanes = active_lanes(wcode, 64, VEC_W);
    else n_lanes = active_lanes(wcode, 32, VEC_W);
  end

  always_comb begin
    raw = '0;
    if (is_double) raw[DP_N-1:0] = dp_hits;
    else raw = sp_hits;
  end

  for (genvar g = 0; g < OUT_W; g++) begin : g_bit
    assign lane_on[g] = (g < n_lanes) && (!mask_en || wmask[g]);
  end

  assign result = raw & lane_on;
endmodule

// File: rtl/fpc_class_unit.sv
module fpc_class_unit
  import fpc_pkg::*;
#(
  parameter int VEC_W = 512,
  localparam int SP_N = VEC_W / 32,
  localparam int DP_N = VEC_W / 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_double,
  input  logic [1:0]       in_width,
  input  logic             in_scalar,
  input  logic             in_mask_en,
  input  logic [CAT_W-1:0] in_imm,
  input  logic [VEC_W-1:0] in_data,
  input  logic [SP_N-1:0]  in_mask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SP_N-1:0]  out_mask
);
  logic [SP_N-1:0] sp_hits;
  logic [DP_N-1:0] dp_hits;
  logic [SP_N-1:0] shaped;
  logic            take;

  fpc_lane_bank #(.LANES(SP_N), .EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) i_sp_bank (
    .data(in_data),
    .sel (in_imm),
    .hits(sp_hits)
  );

  fpc_lane_bank #(.LANES(DP_N), .EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) i_dp_bank (
    .data(in_data),
    .sel (in_imm),
    .hits(dp_hits)
  );

  fpc_mask_shape #(.VEC_W(VEC_W)) i_shape (
    .sp_hits  (sp_hits),
    .dp_hits  (dp_hits),
    .is_double(in_double),
    .wcode    (in_width),
    .scalar   (in_scalar),
    .mask_en  (in_mask_en),
    .wmask    (in_mask),
    .result   (shaped)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_mask  <= shaped;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_mask));
  a_r9_accept_gives_valid: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);
  a_r8_zero_select: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_imm == '0 |=> out_mask == '0);
  a_r6_scalar_upper_clear: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_scalar |=> out_mask[SP_N-1:1] == '0);
  a_r7_write_mask: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_mask_en |=> (out_mask & ~$past(in_mask)) == '0);
  a_r5_double_upper_clear: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_double |=> out_mask[SP_N-1:DP_N] == '0);
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid && out_mask == '0);
endmodule

// File: tb/test_fpc_class_unit.sv
module test_fpc_class_unit;
  logic         clk = 0;
  logic         rst = 1;
  logic         in_valid = 0;
  logic         in_ready;
  logic         in_double = 0;
  logic [1:0]   in_width = 0;
  logic         in_scalar = 0;
  logic         in_mask_en = 0;
  logic [7:0]   in_imm = 0;
  logic [511:0] in_data = 0;
  logic [15:0]  in_mask = 0;
  logic         out_valid;
  logic         out_ready = 1;
  logic [15:0]  out_mask;

  int n_checks = 0;
  int n_fail = 0;
  bit stall_mode = 0;
  int cyc = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  fpc_class_unit i_fpc_class_unit (
    .clk, .rst, .in_valid, .in_ready, .in_double, .in_width, .in_scalar,
    .in_mask_en, .in_imm, .in_data, .in_mask, .out_valid, .out_ready, .out_mask
  );

  always #5 clk = ~clk;

  localparam logic [31:0] S_PINF = 32'h7F80_0000, S_NINF = 32'hFF80_0000;
  localparam logic [31:0] S_PZ = 32'h0, S_NZ = 32'h8000_0000;
  localparam logic [31:0] S_QN = 32'h7FC0_0000, S_SN = 32'h7F80_0001;
  localparam logic [31:0] S_DN = 32'h0000_0001, S_NDN = 32'h8000_0001;
  localparam logic [31:0] S_ONE = 32'h3F80_0000, S_M2 = 32'hC000_0000;
  localparam logic [63:0] D_PINF = 64'h7FF0_0000_0000_0000, D_NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] D_QN = 64'h7FF8_0000_0000_0000, D_SN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] D_DN = 64'h1, D_M1 = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] D_ONE = 64'h3FF0_0000_0000_0000, D_NZ = 64'h8000_0000_0000_0000;

  function automatic bit elem_hit(bit dbl, logic [63:0] w, logic [7:0] imm);
    bit s, eo, ez, fz, qb;
    bit [7:0] c;
    if (dbl) begin
      s = w[63]; eo = (w[62:52] == 11'h7FF); ez = (w[62:52] == 0);
      fz = (w[51:0] == 0); qb = w[51];
    end else begin
      s = w[31]; eo = (w[30:23] == 8'hFF); ez = (w[30:23] == 0);
      fz = (w[22:0] == 0); qb = w[22];
    end
    c[0] = eo && !fz && qb;
    c[7] = eo && !fz && !qb;
    c[1] = ez && fz && !s;
    c[2] = ez && fz && s;
    c[3] = eo && fz && !s;
    c[4] = eo && fz && s;
    c[5] = ez && !fz;
    c[6] = s && !eo && !(ez && fz);
    return (c & imm) != 0;
  endfunction

  function automatic logic [15:0] model(bit dbl, logic [1:0] wc, bit sc, bit me,
                                        logic [7:0] imm, logic [511:0] d, logic [15:0] m);
    logic [15:0] r = 0;
    int bits = (wc == 0) ? 128 : (wc == 1) ? 256 : 512;
    int n = sc ? 1 : bits / (dbl ? 64 : 32);
    for (int i = 0; i < n; i++) begin
      logic [63:0] w = dbl ? d[i*64 +: 64] : {32'h0, d[i*32 +: 32]};
      if (elem_hit(dbl, w, imm) && (!me || m[i])) r[i] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(string tag, bit dbl, logic [1:0] wc, bit sc, bit me,
                      logic [7:0] imm, logic [511:0] d, logic [15:0] m);
    @(negedge clk);
    in_valid = 1; in_double = dbl; in_width = wc; in_scalar = sc;
    in_mask_en = me; in_imm = imm; in_data = d; in_mask = m;
    exp_q.push_back(model(dbl, wc, sc, me, imm, d, m));
    tag_q.push_back(tag);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    in_data = {16{32'hDEAD_BEEF}};
  endtask

  // monitor: pick out_ready for the coming edge, then score the result about to leave
  always @(negedge clk) begin
    cyc++;
    out_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected result", out_mask, 16'hxxxx);
      end else begin
        check(tag_q.pop_front(), out_mask, exp_q.pop_front());
      end
    end
  end

  function automatic logic [511:0] sfill(logic [31:0] v);
    return {16{v}};
  endfunction

  function automatic logic [511:0] dfill(logic [63:0] v);
    return {8{v}};
  endfunction

  initial begin
    #2_000_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [511:0] mix;
    logic [511:0] dmix;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check("R10 reset out_valid", {15'h0, out_valid}, 16'h0);
    check("R10 reset out_mask", out_mask, 16'h0);
    check("R9 idle in_ready", {15'h0, in_ready}, 16'h1);

    mix = {S_ONE, S_PINF, S_NINF, S_PZ, S_NZ, S_M2, S_QN, S_DN,
           S_NDN, S_NINF, S_PINF, S_NZ, S_PZ, S_SN, S_QN, S_M2};
    dmix = {D_ONE, D_PINF, D_NINF, D_NZ, D_M1, D_QN, D_SN, D_DN};

    send("R1 single 0x18 infinities", 0, 2, 0, 0, 8'h18, mix, 16'h0);
    check("R1 literal infinities", model(0, 2, 0, 0, 8'h18, mix, 0), 16'b0110_0000_0110_0000);
    send("R1 single zeros 0x06", 0, 2, 0, 0, 8'h06, mix, 16'h0);
    send("R1 double 0x18", 1, 2, 0, 0, 8'h18, dmix, 16'h0);
    send("R2 single quiet NaN", 0, 2, 0, 0, 8'h01, mix, 16'h0);
    send("R2 single signaling NaN", 0, 2, 0, 0, 8'h80, mix, 16'h0);
    send("R2 double quiet NaN", 1, 2, 0, 0, 8'h01, dmix, 16'h0);
    send("R2 double signaling NaN", 1, 2, 0, 0, 8'h80, dmix, 16'h0);
    send("R3 single denormal", 0, 2, 0, 0, 8'h20, mix, 16'h0);
    send("R3 single negative", 0, 2, 0, 0, 8'h40, mix, 16'h0);
    send("R3 double negative", 1, 2, 0, 0, 8'h40, dmix, 16'h0);
    send("R4 single lane 5 position", 0, 2, 0, 0, 8'h08, (512'(S_PINF) << (5*32)), 16'h0);
    send("R4 double lane 6 position", 1, 2, 0, 0, 8'h10, (512'(D_NINF) << (6*64)), 16'h0);
    send("R5 single 128", 0, 0, 0, 0, 8'h18, sfill(S_PINF), 16'h0);
    send("R5 single 256", 0, 1, 0, 0, 8'h18, sfill(S_NINF), 16'h0);
    send("R5 single code 3", 0, 3, 0, 0, 8'h18, sfill(S_PINF), 16'h0);
    send("R5 double 128", 1, 0, 0, 0, 8'h18, dfill(D_PINF), 16'h0);
    send("R5 double 256", 1, 1, 0, 0, 8'h18, dfill(D_NINF), 16'h0);
    send("R5 double 512", 1, 2, 0, 0, 8'h18, dfill(D_PINF), 16'h0);
    send("R6 scalar single", 0, 2, 1, 0, 8'h18, sfill(S_PINF), 16'h0);
    send("R6 scalar double", 1, 2, 1, 0, 8'h18, dfill(D_NINF), 16'h0);
    send("R7 write mask single", 0, 2, 0, 1, 8'h18, sfill(S_PINF), 16'hA5C3);
    send("R7 write mask double", 1, 2, 0, 1, 8'h18, dfill(D_PINF), 16'h00AA);
    send("R7 mask ignored when disabled", 0, 2, 0, 0, 8'h18, sfill(S_PINF), 16'h0000);
    send("R8 zero select", 0, 2, 0, 0, 8'h00, mix, 16'hFFFF);
    send("R8 zero select double", 1, 2, 0, 0, 8'h00, dfill(D_QN), 16'hFFFF);

    stall_mode = 1;
    for (int k = 0; k < 12; k++) begin
      send("R9 stalled stream", k[0], 2'(k % 3), 0, k[1], 8'(8'h01 << (k % 8)),
           k[0] ? dmix : mix, 16'(16'h3C5A ^ k));
    end
    wait (exp_q.size() == 0);
    stall_mode = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R9 drained out_valid", {15'h0, out_valid}, 16'h0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule